// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the bit-rate ticks for a serial port's transmit and receive sides. A 16-bit up-counter advances once per enable pulse taken from a prescaled oscillator. Each time it passes its all-ones value it reloads a start value that software has written into a preset register. Each of these rollovers is one overflow event. The serial bit rate is the overflow rate divided by 16.

Each direction has its own select input. When a select is high, that direction takes its events from this timer's overflows. When it is low, the direction takes them from an alternate timer's overflow pulse input. The two directions can therefore run at different rates. Each direction has its own divide-by-16 counter, and each counter emits a one-cycle tick.

The block is in generator mode while either select is in effect. In that mode, overflows are kept off the timer's overflow flag. In the other mode the flag records overflows until software clears it.

Top module: `baud_tick_gen`

## Requirements
- R1: The counter advances by one on every clock where `cnt_en` is high and holds when it is low. After reset it holds all ones, so the first enabled clock loads the preset.
- R2: An enabled clock that finds the counter at all ones is an overflow event. On that clock the counter reloads the value of the preset register, which `preset_we`/`preset_data` write.
- R3: Each tick output is a registered one-cycle pulse. It is high on the clock after every 16th event counted for that direction.
- R4: With the effective transmit select at 1, transmit events are the timer's overflows. At 0 they are the `alt_ovf` pulses. The steady transmit tick period is 16 × (65536 − preset) enabled clocks, or 16 alternate pulses.
- R5: Receive follows the same rule through its own select and divider, independently of transmit. The two directions can run at different rates.
- R6: `ovf_flag` is set by an overflow only when both effective selects are 0. It is cleared by `flag_clr`, and a set on the same clock wins over the clear.
- R7: Changes on `tx_sel`/`rx_sel` take effect only at the next overflow event. The event on that clock is still counted under the old selection.
- R8: At the overflow where the effective selects go from both 0 to not both 0, both dividers clear and that event is not counted. The first tick of a timer-fed direction therefore follows 16 later overflows.
- R9: While reset is asserted, both tick outputs and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Prescaled count enable, one pulse per timer increment |
| preset_we | input | 1 | Write strobe for the preset register |
| preset_data | input | 16 | Reload value written on `preset_we` |
| tx_sel | input | 1 | 1: transmit clocked by this timer; 0: by `alt_ovf` |
| rx_sel | input | 1 | 1: receive clocked by this timer; 0: by `alt_ovf` |
| alt_ovf | input | 1 | One-cycle overflow pulse of the alternate timer |
| flag_clr | input | 1 | Clears `ovf_flag` |
| tx_tick | output | 1 | Transmit bit-rate tick |
| rx_tick | output | 1 | Receive bit-rate tick |
| ovf_flag | output | 1 | Sticky overflow flag, not set in generator mode |

## Verification
The hardest situations to reach from the ports are the deferred select change and the divider clear on mode entry. Both hide inside the steady tick periods, because any divider phase settles out after one tick. The bench reaches them by freezing the timer with `cnt_en` low. While frozen, it parks both dividers at a known phase with an exact burst of five alternate pulses, then flips a select. It then releases the timer with the preset at all ones, so every clock is an overflow. The first tick must then arrive after exactly 17 clocks. A later burst of alternate pulses, sent after the transmit select drops while the timer is frozen, must reach only the receive side.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef struct packed {
    logic tx;
    logic rx;
  } dir_sel_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_TX  = 0;
  localparam int unsigned DIR_RX  = 1;

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_data,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] preset_q, preset_d;
  logic             at_top;

  always_comb begin
    at_top   = (count_q == ALL_ONES);
    ovf      = cnt_en && at_top;
    preset_d = preset_we ? preset_data : preset_q;
    count_d  = count_q;
    if (cnt_en) begin
      count_d = at_top ? preset_q : count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= ALL_ONES;
      preset_q <= '0;
    end else begin
      count_q  <= count_d;
      preset_q <= preset_d;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !at_top) |=> (count_q == $past(count_q) + CNT_W'(1))); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count_q)); // R1
  AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count_q == $past(preset_q))); // R2

endmodule

// File: rtl/baud_src_select.sv
module baud_src_select
  import baud_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic tx_sel,
  input  logic rx_sel,
  input  logic alt_ovf,
  input  logic flag_clr,
  output logic tx_evt,
  output logic rx_evt,
  output logic div_clr,
  output logic ovf_flag
);

  dir_sel_t eff_q, eff_d, req;
  logic     gen_mode;
  logic     flag_q, flag_d;

  always_comb begin
    req.tx   = tx_sel;
    req.rx   = rx_sel;
    gen_mode = eff_q.tx | eff_q.rx;
    eff_d    = ovf ? req : eff_q;
    div_clr  = ovf && !gen_mode && (req.tx | req.rx);
    tx_evt   = eff_q.tx ? ovf : alt_ovf;
    rx_evt   = eff_q.rx ? ovf : alt_ovf;
    flag_d   = flag_q;
    if (ovf && !gen_mode) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      eff_q  <= eff_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;

  AST_SEL_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(eff_q)); // R7
  AST_FLAG_QUIET_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode && !flag_q) |=> !flag_q); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(ovf && !gen_mode)); // R6

endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic tick
);

  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  always_comb begin
    wrap   = evt && (cnt_q == LAST);
    tick_d = !clr && wrap;
    cnt_d  = cnt_q;
    if (clr || wrap) begin
      cnt_d = '0;
    end else if (evt) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R3
  AST_TICK_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ($past(evt) && cnt_q == '0)); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !tick_q)); // R8

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_data,
  input  logic             tx_sel,
  input  logic             rx_sel,
  input  logic             alt_ovf,
  input  logic             flag_clr,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             ovf_flag
);

  logic               rst_i_n;
  logic               ovf;
  logic               div_clr;
  logic [NUM_DIR-1:0] evt;
  logic [NUM_DIR-1:0] tick;

  baud_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  baud_reload_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cnt_en      (cnt_en),
    .preset_we   (preset_we),
    .preset_data (preset_data),
    .ovf         (ovf)
  );

  baud_src_select u_select (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ovf      (ovf),
    .tx_sel   (tx_sel),
    .rx_sel   (rx_sel),
    .alt_ovf  (alt_ovf),
    .flag_clr (flag_clr),
    .tx_evt   (evt[DIR_TX]),
    .rx_evt   (evt[DIR_RX]),
    .div_clr  (div_clr),
    .ovf_flag (ovf_flag)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    baud_tick_div #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_i_n),
      .evt   (evt[d]),
      .clr   (div_clr),
      .tick  (tick[d])
    );
  end

  assign tx_tick = tick[DIR_TX];
  assign rx_tick = tick[DIR_RX];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> (!tx_tick && !rx_tick && !ovf_flag)); // R9

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n, cnt_en, preset_we, tx_sel, rx_sel, alt_ovf, flag_clr;
  logic [15:0] preset_data;
  logic        tx_tick, rx_tick, ovf_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int alt_per   = 0;
  int alt_burst = 0;
  int acnt      = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .preset_we(preset_we),
    .preset_data(preset_data), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .alt_ovf(alt_ovf), .flag_clr(flag_clr), .tx_tick(tx_tick),
    .rx_tick(rx_tick), .ovf_flag(ovf_flag)
  );

  // {preset, tx_sel, rx_sel, alt period, expected tx period, expected rx period}
  localparam logic [57:0] VEC [5] = '{
    {16'hFFF0, 1'b1, 1'b1, 8'd20, 16'd256, 16'd256},
    {16'hFFF0, 1'b1, 1'b0, 8'd20, 16'd256, 16'd320},
    {16'hFFE8, 1'b0, 1'b1, 8'd12, 16'd192, 16'd384},
    {16'hFFFF, 1'b1, 1'b1, 8'd7,  16'd16,  16'd16 },
    {16'hFFF8, 1'b0, 1'b0, 8'd10, 16'd160, 16'd160}
  };

  // alternate timer model: periodic pulses or an exact burst
  initial begin
    alt_ovf = 1'b0;
    forever begin
      @(negedge clk);
      if (alt_burst > 0) begin
        alt_ovf = 1'b1;
        alt_burst--;
      end else if (alt_per == 0) begin
        alt_ovf = 1'b0;
        acnt = 0;
      end else if (acnt >= alt_per - 1) begin
        alt_ovf = 1'b1;
        acnt = 0;
      end else begin
        alt_ovf = 1'b0;
        acnt++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit use_rx, output int per);
    int seen = 0;
    int t3 = 0;
    per = 0;
    while (seen < 4) begin
      @(negedge clk);
      if (use_rx ? rx_tick : tx_tick) begin
        seen++;
        if (seen == 3) t3 = cyc;
        if (seen == 4) per = cyc - t3;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ptx, prx, n, ntx, nrx;
    rst_n = 1'b0; cnt_en = 1'b0; preset_we = 1'b0; preset_data = '0;
    tx_sel = 1'b0; rx_sel = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 tx_tick in reset", int'(tx_tick), 0);
    chk("R9 rx_tick in reset", int'(rx_tick), 0);
    chk("R9 ovf_flag in reset", int'(ovf_flag), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      preset_data = VEC[i][57:42];
      preset_we   = 1'b1;
      tx_sel      = VEC[i][41];
      rx_sel      = VEC[i][40];
      alt_per     = int'(VEC[i][39:32]);
      cnt_en      = 1'b1;
      @(negedge clk);
      preset_we   = 1'b0;
      fork
        measure(1'b0, ptx);
        measure(1'b1, prx);
      join
      chk($sformatf("R2 R3 R4 tx period vec %0d", i), ptx, int'(VEC[i][31:16]));
      chk($sformatf("R2 R3 R5 rx period vec %0d", i), prx, int'(VEC[i][15:0]));
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      repeat (2 * (65536 - int'(VEC[i][57:42])) + 4) @(negedge clk);
      chk($sformatf("R6 flag vec %0d", i), int'(ovf_flag),
          int'(!(VEC[i][41] | VEC[i][40])));
    end

    // overflow every enabled clock, both directions on the alternate source
    preset_data = 16'hFFFF;
    preset_we   = 1'b1;
    @(negedge clk);
    preset_we   = 1'b0;
    repeat (40) @(negedge clk);
    while (!tx_tick) @(negedge clk);
    alt_per = 0;
    repeat (3) @(negedge clk);
    alt_burst = 5;
    repeat (10) @(negedge clk);

    // timer frozen: a raised select has nothing to act on
    cnt_en = 1'b0;
    tx_sel = 1'b1;
    ntx = 0;
    repeat (40) begin
      @(negedge clk);
      if (tx_tick) ntx++;
    end
    chk("R1 R7 no tx tick while timer frozen", ntx, 0);

    // release: entering overflow clears dividers, then 16 counted overflows
    cnt_en = 1'b1;
    n = 0;
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (tx_tick) break;
    end
    cnt_en = 1'b0;
    chk("R8 clocks to first tick after mode entry", n, 17);

    // drop tx select while frozen: alternate pulses reach only receive
    tx_sel = 1'b0;
    alt_burst = 20;
    ntx = 0;
    nrx = 0;
    repeat (40) begin
      @(negedge clk);
      if (tx_tick) ntx++;
      if (rx_tick) nrx++;
    end
    chk("R7 tx ignores alt pulses before next overflow", ntx, 0);
    chk("R5 rx ticks from 20 alt pulses", nrx, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule